// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Permute Unit

This unit operates on a 64-bit operand split into 16-bit, 32-bit or 64-bit lanes. It does logical left and right shifts, arithmetic right shifts and right rotates, and keeps every bit movement inside its own lane. It also rearranges halfwords under an 8-bit selector, and it extracts eight consecutive bytes from the 128-bit concatenation of two operands. For shift, rotate and shuffle results it produces a 32-bit word of per-lane negative and zero flags.

Each operation is started by one pulse on `valid_i`. The result and the flags are registered and appear together one cycle later. Between operations the outputs keep their last value. Storing the flag word is left to the surrounding datapath.

Top module: `lane_shift_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `res_o` and `flags_o` are all zero.
- R2: A pulse on `valid_i` produces `res_o`/`flags_o` and a one-cycle `valid_o` pulse at the next rising edge. When `valid_i` is low, both outputs hold their previous value.
- R3: `op_i`=0 is a logical left shift and `op_i`=1 is a logical right shift of each lane of `x_i` by `cnt_i`. The lane width is chosen by `lane_i`: 0 selects 16 bits, 1 selects 32 bits, 2 or 3 select 64 bits. Bits that cross a lane edge are lost and vacated bits are zero. A count of at least the lane width gives zero.
- R4: `op_i`=2 is an arithmetic right shift per lane that fills with the lane's sign bit. A count of at least the lane width gives a lane of copies of its sign bit.
- R5: `op_i`=3 rotates each lane right. Bits that leave the bottom of a lane re-enter at the top of the same lane. The count is taken modulo the lane width.
- R6: `op_i`=4 is a halfword shuffle. Output halfword k (bits 16k+15..16k) is input halfword `cnt_i[2k+1:2k]` of `x_i`. `lane_i` is ignored.
- R7: `op_i`=5 is a byte align with n = `cnt_i[2:0]`. It returns bits 63..0 of `{y_i, x_i} >> 8n`, so n = 0 returns `x_i`. `cnt_i[7:3]` is ignored.
- R8: For ops 0..4, lane k of width W (W = 16 for the shuffle) owns a flag field of W/2 bits starting at bit k·W/2. In that field, the top bit is the lane's MSB (N) and the bit below it is 1 when the lane is zero (Z). All other flag bits are 0. For 64-bit lanes this places N at bit 31 and Z at bit 30.
- R9: The align op gives an all-zero flag word. The reserved codes `op_i`=6 and 7 give zero for both the result and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Starts an operation |
| op_i | input | 3 | Operation code |
| lane_i | input | 2 | Lane width select |
| cnt_i | input | 8 | Shift count, shuffle selector or align byte count |
| x_i | input | 64 | Main operand |
| y_i | input | 64 | Upper operand for align |
| valid_o | output | 1 | Result valid pulse |
| res_o | output | 64 | Result |
| flags_o | output | 32 | Per-lane N/Z flag word |

## Verification
The result, the flags and the valid pulse all come from a single register stage. They are due at the first rising edge after `valid_i` is sampled high. The bench drives each operation on a falling edge, drops `valid_i` on the next falling edge, and compares the outputs there, half a cycle after the edge that loaded them. One further falling edge with `valid_i` low, and with the inputs changed, confirms that the outputs hold.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [2:0] OP_SLL   = 3'd0;
  localparam logic [2:0] OP_SRL   = 3'd1;
  localparam logic [2:0] OP_SRA   = 3'd2;
  localparam logic [2:0] OP_ROR   = 3'd3;
  localparam logic [2:0] OP_SHUF  = 3'd4;
  localparam logic [2:0] OP_ALIGN = 3'd5;
  localparam int unsigned N_WIDTHS = 3;  // 16, 32, 64-bit lanes
endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [2:0]        op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned SH_W  = $clog2(LANE_W);

  logic [SH_W-1:0] sh;
  logic            over;
  assign sh   = cnt_i[SH_W-1:0];
  assign over = (cnt_i >= CNT_W'(LANE_W));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0]   d, sll_v, srl_v, sra_v, ror_v;
    logic [2*LANE_W-1:0] dd;
    assign d     = data_i[k*LANE_W +: LANE_W];
    assign sll_v = over ? '0 : (d << sh);
    assign srl_v = over ? '0 : (d >> sh);
    assign sra_v = over ? {LANE_W{d[LANE_W-1]}} : LANE_W'($signed(d) >>> sh);
    assign dd    = {d, d} >> sh;   // rotate uses count modulo lane width
    assign ror_v = dd[LANE_W-1:0];

    always_comb begin
      unique case (op_i)
        OP_SLL:  res_o[k*LANE_W +: LANE_W] = sll_v;
        OP_SRL:  res_o[k*LANE_W +: LANE_W] = srl_v;
        OP_SRA:  res_o[k*LANE_W +: LANE_W] = sra_v;
        default: res_o[k*LANE_W +: LANE_W] = ror_v;
      endcase
    end
  end
endmodule

// File: rtl/perm_unit.sv
module perm_unit #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [7:0]        sel_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] shuf_o,
  output logic [DATA_W-1:0] align_o
);
  localparam int unsigned HW    = 16;
  localparam int unsigned N_HW  = DATA_W / HW;
  localparam int unsigned SEL_W = $clog2(N_HW);

  for (genvar k = 0; k < N_HW; k++) begin : g_hw
    logic [SEL_W-1:0] src;
    assign src = sel_i[k*SEL_W +: SEL_W];
    assign shuf_o[k*HW +: HW] = x_i[src*HW +: HW];
  end

  logic [2*DATA_W-1:0] cat;
  assign cat     = {y_i, x_i} >> {sel_i[2:0], 3'b000};
  assign align_o = cat[DATA_W-1:0];
endmodule

// File: rtl/nz_flags.sv
module nz_flags #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned FLAG_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned FW    = FLAG_W / LANES;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic n, z;
    assign n = res_i[k*LANE_W + LANE_W - 1];
    assign z = ~|res_i[k*LANE_W +: LANE_W];
    assign flags_o[k*FW +: FW] = {n, z, {(FW-2){1'b0}}};
  end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DATA_W-1:0] sh_res [N_WIDTHS];
  logic [FLAG_W-1:0] fl     [N_WIDTHS];
  logic [DATA_W-1:0] shuf_v, align_v, res_c;
  logic [FLAG_W-1:0] flags_c;
  logic [1:0]        wsel;

  assign wsel = lane_i[1] ? 2'd2 : {1'b0, lane_i[0]};

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_w
    lane_shifter #(.DATA_W(DATA_W), .LANE_W(16 << g), .CNT_W(CNT_W)) u_sh (
      .op_i  (op_i),
      .cnt_i (cnt_i),
      .data_i(x_i),
      .res_o (sh_res[g])
    );
    nz_flags #(.DATA_W(DATA_W), .LANE_W(16 << g), .FLAG_W(FLAG_W)) u_fl (
      .res_i  (res_c),
      .flags_o(fl[g])
    );
  end

  perm_unit #(.DATA_W(DATA_W)) u_perm (
    .sel_i  (cnt_i[7:0]),
    .x_i    (x_i),
    .y_i    (y_i),
    .shuf_o (shuf_v),
    .align_o(align_v)
  );

  always_comb begin
    res_c   = '0;
    flags_c = '0;
    case (op_i)
      OP_SLL, OP_SRL, OP_SRA, OP_ROR: begin
        res_c   = sh_res[wsel];
        flags_c = fl[wsel];
      end
      OP_SHUF: begin
        res_c   = shuf_v;
        flags_c = fl[0];
      end
      OP_ALIGN: res_c = align_v;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_c;
        flags_o <= flags_c;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(res_o) && $stable(flags_o)));
  p_sll_wide_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_SLL && lane_i == 2'd0 && cnt_i >= CNT_W'(16))
    |-> res_o == '0);
  p_sra_wide_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_SRA && lane_i[1] && cnt_i >= CNT_W'(DATA_W))
    |-> res_o == {DATA_W{$past(x_i[DATA_W-1])}});
  p_align_ident_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_ALIGN && cnt_i[2:0] == 3'd0)
    |-> res_o == $past(x_i));
  p_no_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i >= OP_ALIGN) |-> flags_o == '0);
endmodule

// File: tb/tb_lane_shift_unit.sv
module tb_lane_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  lane_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [63:0] x_i = '0, y_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic [31:0] flags_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  lane_shift_unit dut (.*);

  function automatic int width_of(input logic [2:0] op, input logic [1:0] ln);
    if (op == 3'd4) return 16;
    return ln[1] ? 64 : (ln[0] ? 32 : 16);
  endfunction

  function automatic logic [63:0] ref_res(input logic [2:0] op, input logic [1:0] ln,
                                          input logic [63:0] x, input logic [63:0] y,
                                          input int c);
    logic [63:0] r = '0;
    int w = width_of(op, ln);
    for (int i = 0; i < 64; i++) begin
      int b = (i / w) * w;
      int p = i - b;
      int s;
      case (op)
        3'd0: r[i] = (c < w && p - c >= 0) ? x[b + p - c] : 1'b0;
        3'd1: r[i] = (p + c < w) ? x[b + p + c] : 1'b0;
        3'd2: begin s = p + c; if (s > w - 1) s = w - 1; r[i] = x[b + s]; end
        3'd3: r[i] = x[b + ((p + (c % w)) % w)];
        3'd5: begin s = i + 8 * (c % 8); r[i] = (s < 64) ? x[s] : y[s - 64]; end
        default: r[i] = 1'b0;
      endcase
    end
    if (op == 3'd4)
      for (int k = 0; k < 4; k++) begin
        int src = (c >> (2 * k)) & 3;
        r[16*k +: 16] = x[16*src +: 16];
      end
    return r;
  endfunction

  function automatic logic [31:0] ref_fl(input logic [2:0] op, input logic [1:0] ln,
                                         input logic [63:0] r);
    logic [31:0] f = '0;
    int w = width_of(op, ln);
    if (op > 3'd4) return f;
    for (int k = 0; k < 64 / w; k++) begin
      logic z = 1'b1;
      for (int j = 0; j < w; j++) if (r[k*w + j]) z = 1'b0;
      f[(w/2)*(k+1) - 1] = r[k*w + w - 1];
      f[(w/2)*(k+1) - 2] = z;
    end
    return f;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one op, sample half a cycle after the loading edge
  task automatic run_op(input logic [2:0] op, input logic [1:0] ln, input logic [63:0] x,
                        input logic [63:0] y, input logic [7:0] c);
    logic [63:0] er;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; lane_i = ln; cnt_i = c; x_i = x; y_i = y;
    @(negedge clk_i);
    valid_i = 1'b0;
    er = ref_res(op, ln, x, y, int'(c));
    check(tag_of(op), res_o, er);
    if (op == 3'd5) check("R9 align flags", 64'(flags_o), 64'(ref_fl(op, ln, er)));
    else            check("R8", 64'(flags_o), 64'(ref_fl(op, ln, er)));
    check("R2 valid", 64'(valid_o), 64'd1);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 valid", 64'(valid_o), 64'd0);
    check("R1 res", res_o, 64'd0);
    check("R1 flags", 64'(flags_o), 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_shift_sweep;
    logic [63:0] pats [3] = '{64'hF00D_8001_1234_C0DE, 64'h0123_4567_89AB_CDEF,
                              64'h8000_0000_7FFF_0001};
    for (int op = 0; op < 4; op++)
      for (int ln = 0; ln < 4; ln++)
        for (int p = 0; p < 3; p++) begin
          for (int c = 0; c < 64; c++)
            run_op(3'(op), 2'(ln), pats[p], 64'h0, 8'(c));
          run_op(3'(op), 2'(ln), pats[p], 64'h0, 8'd100);
          run_op(3'(op), 2'(ln), pats[p], 64'h0, 8'd255);
        end
  endtask

  task automatic t_zero_lanes;  // R8 zero flags on cleared lanes
    run_op(3'd0, 2'd0, 64'h0000_FFFF_0000_8000, 64'h0, 8'd1);
    run_op(3'd1, 2'd2, 64'h0, 64'h0, 8'd0);
  endtask

  task automatic t_shuffle;  // R6
    logic [7:0] sels [5] = '{8'h00, 8'hE4, 8'h1B, 8'hFF, 8'h9C};
    for (int s = 0; s < 5; s++)
      for (int ln = 0; ln < 4; ln++)
        run_op(3'd4, 2'(ln), 64'h8000_0000_7A7A_0102, 64'h0, sels[s]);
  endtask

  task automatic t_align;  // R7, upper count bits ignored
    for (int n = 0; n < 8; n++) begin
      run_op(3'd5, 2'd0, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'(n));
      run_op(3'd5, 2'd2, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, 8'(n | 8'hF8));
    end
  endtask

  task automatic t_reserved;  // R9
    run_op(3'd6, 2'd0, 64'hDEAD_BEEF_0000_1111, 64'h1, 8'd3);
    run_op(3'd7, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 8'd0);
  endtask

  task automatic t_hold;  // R2
    logic [63:0] er;
    run_op(3'd3, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0, 8'd4);
    er = ref_res(3'd3, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0, 4);
    x_i = 64'h5555_5555_5555_5555; op_i = 3'd0; cnt_i = 8'd1;
    @(negedge clk_i);
    check("R2 hold res", res_o, er);
    check("R2 hold flags", 64'(flags_o), 64'(ref_fl(3'd3, 2'd1, er)));
    check("R2 valid drop", 64'(valid_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_sweep();
    t_zero_lanes();
    t_shuffle();
    t_align();
    t_reserved();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule